// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames on a single output line. An external divisor-based baud generator paces it with a one-cycle enable pulse at sixteen times the bit rate. Each frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and a high stop period of one, one and a half or two bit times. When no frame is being sent, the line rests high.

Software sets the character length, the parity mode, the stop length and a break control on static configuration inputs. Characters are written through a one-cycle write strobe. In character mode a single holding slot sits in front of the shift register. In buffered mode a FIFO of `FIFO_DEPTH` entries sits there instead. Two flags report whether the buffer is empty and whether the whole transmitter is empty.

Top module: `serial_frame_tx`

## Requirements
- R1: `cfg_len_sel` selects 5 + `cfg_len_sel` data bits (0 gives 5, 3 gives 8). Data bits are sent least significant bit first, and bits of `wr_data` above the selected length are never sent.
- R2: Each frame begins with a start bit that holds `txd` low for 16 ticks. The frame lasts 16·(1 + data bits + parity bit) ticks plus the stop period.
- R3: With `cfg_par_en` high, one parity bit follows the data. With `cfg_par_odd` low the count of ones in data plus parity is even, and with it high that count is odd. With `cfg_par_en` low, no parity bit is sent.
- R4: The stop period is high for 16 ticks when `cfg_stop_long` is 0. When it is 1, the stop period is 24 ticks for 5-bit characters and 32 ticks for 6 to 8 bit characters.
- R5: The frame advances only on cycles where `tick_16x` is high. Without ticks the line holds its current bit.
- R6: With `cfg_fifo_mode` low, the buffer holds one character. A write while it is occupied is dropped. `buf_empty` is low while the slot holds a character.
- R7: With `cfg_fifo_mode` high, up to `FIFO_DEPTH` characters are sent in write order. A write to a full FIFO is dropped.
- R8: A change of `cfg_fifo_mode` empties the buffer on the next clock edge, and the frame already in the shift register is still completed.
- R9: While `cfg_break` is high, `txd` is low whatever the frame state. Once it drops, the line returns to its normal level.
- R10: After reset `txd`, `buf_empty` and `tx_idle` are high. `tx_idle` is high only when both the buffer and the shift register are empty, and the line is high whenever `tx_idle` is high and break is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_16x | input | 1 | Enable pulse at 16 times the bit rate |
| cfg_len_sel | input | 2 | Character length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | Odd parity when high, even when low |
| cfg_stop_long | input | 1 | Long stop period (1.5 or 2 bits) |
| cfg_break | input | 1 | Force the line low |
| cfg_fifo_mode | input | 1 | Buffered mode when high, character mode when low |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | CHAR_W | Character to send |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding slot or FIFO is empty |
| tx_idle | output | 1 | Buffer and shift register both empty |

## Verification
The assertions assume that the framing inputs (`cfg_len_sel`, `cfg_par_en`, `cfg_par_odd`, `cfg_stop_long`) change only while `tx_idle` is high, and that `tick_16x` is a one-cycle pulse that is never stretched. The block latches the framing settings when a frame starts, so the timing checks only hold when the settings are steady at that moment. The stimulus changes configuration only between frames, when the line is idle. It then waits two cycles before writing, so a mode change and its flush never coincide with a write. Ticks come from a bench divider that is either stopped, runs every cycle or runs every third cycle.

// File: rtl/sftx_pkg.sv
package sftx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_START = 3'd1,
      ST_DATA  = 3'd2,
      ST_PAR   = 3'd3,
      ST_STOP  = 3'd4
   } tx_state_e;

   typedef struct packed {
      logic [1:0] len_sel;
      logic       par_en;
      logic       par_odd;
      logic       stop_long;
   } frame_cfg_t;

endpackage

// File: rtl/sftx_buffer.sv
module sftx_buffer #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             deep_mode,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] pop_data,
   output logic             empty,
   output logic             full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   logic [WIDTH-1:0] slots [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count, cap;
   logic             push_ok, pop_ok;

   assign cap     = deep_mode ? CW'(DEPTH) : CW'(1);
   assign full    = (count >= cap);
   assign empty   = (count == '0);
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (push_ok && (wr_ptr == AW'(g))) slots[g] <= push_data;
         end
      end
   endgenerate

   assign pop_data = slots[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: a write to a full buffer leaves the fill level unchanged
   a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> (count == $past(count)));

   // R6: character mode never holds more than one entry
   a_r6_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (!deep_mode && !$past(deep_mode)) |-> (count <= CW'(1)));

endmodule

// File: rtl/sftx_shifter.sv
module sftx_shifter
   import sftx_pkg::*;
#(
   parameter int CHAR_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  frame_cfg_t        cfg,
   input  logic              avail,
   input  logic [CHAR_W-1:0] data,
   output logic              take,
   output logic              line,
   output logic              idle
);
   localparam int IW = $clog2(CHAR_W);
   localparam int CW = $clog2(2 * OVS);

   tx_state_e         state;
   logic [CW-1:0]     cnt, stop_last, per_last, stop_last_n;
   logic [IW-1:0]     bit_idx, bits_last, bits_last_n;
   logic [CHAR_W-1:0] shreg, mask;
   logic              par_bit, par_en_q, at_end;

   always_comb begin
      bits_last_n = IW'(CHAR_W - 4) + IW'(cfg.len_sel);
      for (int i = 0; i < CHAR_W; i++) mask[i] = (IW'(i) <= bits_last_n);
      if (!cfg.stop_long)          stop_last_n = CW'(OVS - 1);
      else if (cfg.len_sel == 2'd0) stop_last_n = CW'(OVS + OVS / 2 - 1);
      else                         stop_last_n = CW'(2 * OVS - 1);
   end

   assign per_last = (state == ST_STOP) ? stop_last : CW'(OVS - 1);
   assign at_end   = (cnt == per_last);
   assign take     = (state == ST_IDLE) && avail;
   assign idle     = (state == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         bit_idx   <= '0;
         bits_last <= '0;
         stop_last <= '0;
         shreg     <= '0;
         par_bit   <= 1'b0;
         par_en_q  <= 1'b0;
      end else if (state == ST_IDLE) begin
         if (avail) begin
            shreg     <= data;
            par_bit   <= (^(data & mask)) ^ cfg.par_odd;
            par_en_q  <= cfg.par_en;
            bits_last <= bits_last_n;
            stop_last <= stop_last_n;
            bit_idx   <= '0;
            cnt       <= '0;
            state     <= ST_START;
         end
      end else if (tick) begin
         if (!at_end) begin
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
            case (state)
               ST_START: state <= ST_DATA;
               ST_DATA: begin
                  if (bit_idx == bits_last) begin
                     state <= par_en_q ? ST_PAR : ST_STOP;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     shreg   <= {1'b0, shreg[CHAR_W-1:1]};
                  end
               end
               ST_PAR:  state <= ST_STOP;
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (state)
         ST_START: line = 1'b0;
         ST_DATA:  line = shreg[0];
         ST_PAR:   line = par_bit;
         default:  line = 1'b1;
      endcase
   end

   // R1: the data phase ends only after the last selected bit
   a_r1_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_DATA && state != ST_DATA) |-> ($past(bit_idx) == $past(bits_last)));

   // R4: the stop period ends only when its latched length has elapsed
   a_r4_stop_len: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_STOP && state == ST_IDLE) |-> ($past(cnt) == $past(stop_last)));

   // R5: with no tick the frame does not move
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && state != ST_IDLE) |=> ($stable(state) && $stable(cnt)));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
   import sftx_pkg::*;
#(
   parameter int CHAR_W     = 8,
   parameter int OVS        = 16,
   parameter int FIFO_DEPTH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_16x,
   input  logic [1:0]        cfg_len_sel,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop_long,
   input  logic              cfg_break,
   input  logic              cfg_fifo_mode,
   input  logic              wr_en,
   input  logic [CHAR_W-1:0] wr_data,
   output logic              txd,
   output logic              buf_empty,
   output logic              tx_idle
);
   generate
      if (CHAR_W != 8) begin : g_bad_width
         initial $error("serial_frame_tx: CHAR_W must be 8 for a 2-bit length select");
      end
      if (OVS < 2 || (OVS % 2) != 0) begin : g_bad_ovs
         initial $error("serial_frame_tx: OVS must be even and at least 2");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
         initial $error("serial_frame_tx: FIFO_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   frame_cfg_t        cfg;
   logic              mode_q, flush, sh_take, sh_line, sh_idle, buf_full;
   logic [CHAR_W-1:0] head;

   assign cfg = '{len_sel: cfg_len_sel, par_en: cfg_par_en, par_odd: cfg_par_odd,
                  stop_long: cfg_stop_long};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= cfg_fifo_mode;
   end
   assign flush = (cfg_fifo_mode != mode_q);

   sftx_buffer #(.WIDTH(CHAR_W), .DEPTH(FIFO_DEPTH)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .deep_mode (cfg_fifo_mode),
      .push      (wr_en),
      .push_data (wr_data),
      .pop       (sh_take),
      .pop_data  (head),
      .empty     (buf_empty),
      .full      (buf_full)
   );

   sftx_shifter #(.CHAR_W(CHAR_W), .OVS(OVS)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick_16x),
      .cfg   (cfg),
      .avail (!buf_empty && !flush),
      .data  (head),
      .take  (sh_take),
      .line  (sh_line),
      .idle  (sh_idle)
   );

   assign txd     = cfg_break ? 1'b0 : sh_line;
   assign tx_idle = buf_empty && sh_idle;

   // R10: an idle transmitter with break off keeps the line high
   a_r10_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_idle && !cfg_break) |-> txd);

   // R8: a mode change leaves the buffer empty one edge later
   a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fifo_mode != mode_q) |=> buf_empty);

   // R7: a full buffer reports not empty
   a_r7_full_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full |-> !buf_empty);

endmodule

// File: tb/test_serial_frame_tx.sv
`timescale 1ns/1ps
module test_serial_frame_tx;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_16x = 1'b0;
   logic [1:0] cfg_len_sel = 2'd3;
   logic       cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop_long = 1'b0;
   logic       cfg_break = 1'b0, cfg_fifo_mode = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       txd, buf_empty, tx_idle;

   int checks = 0, errors = 0, cyc = 0, tick_mode = 0, divc = 0;

   always #2.5 clk = ~clk;

   serial_frame_tx i_serial_frame_tx (
      .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x), .cfg_len_sel(cfg_len_sel),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop_long(cfg_stop_long),
      .cfg_break(cfg_break), .cfg_fifo_mode(cfg_fifo_mode), .wr_en(wr_en),
      .wr_data(wr_data), .txd(txd), .buf_empty(buf_empty), .tx_idle(tx_idle));

   always @(negedge clk) begin
      divc = (divc == 2) ? 0 : divc + 1;
      if (tick_mode == 1)      tick_16x <= 1'b1;
      else if (tick_mode == 3) tick_16x <= (divc == 0);
      else                     tick_16x <= 1'b0;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // fields: data, len_sel, par_en, par_odd, stop_long, fifo_mode
   localparam logic [13:0] VEC [8] = '{
      {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
      {8'h3C, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},
      {8'hFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0},
      {8'hEA, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0},
      {8'h7F, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1},
      {8'hE0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
      {8'hFF, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int frame_ticks(input int n, input int p, input int sl);
      return 16 * (1 + n + p) + (sl == 0 ? 16 : (n == 5 ? 24 : 32));
   endfunction

   task automatic wr(input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   // Samples each bit at its middle; returns with i at the stop-bit middle.
   task automatic recv(input int n, input int p, output logic [15:0] bits, output int i);
      int nb;
      nb = 1 + n + p;
      bits = '0;
      do @(negedge clk); while (txd !== 1'b0);
      i = 0;
      while (i < 16 * nb + 8) begin
         @(negedge clk);
         i++;
         if (i % 16 == 8) bits[i / 16] = txd;
      end
   endtask

   function automatic logic [7:0] decode(input logic [15:0] bits, input int n);
      logic [7:0] d;
      d = '0;
      for (int j = 0; j < n; j++) d[j] = bits[1 + j];
      return d;
   endfunction

   task automatic wait_idle(inout int i);
      while (tx_idle !== 1'b1) begin @(negedge clk); i++; end
   endtask

   initial begin
      logic [15:0] bits;
      int          i, n, p, sl, t;
      logic [7:0]  d, exp_d;
      logic        exp_p;

      repeat (3) @(negedge clk);
      check(txd === 1'b1, "R10 reset txd", int'(txd), 1);
      check(buf_empty === 1'b1, "R10 reset buf_empty", int'(buf_empty), 1);
      check(tx_idle === 1'b1, "R10 reset tx_idle", int'(tx_idle), 1);
      rst_n = 1'b1;
      tick_mode = 1;
      repeat (3) @(negedge clk);
      check(txd === 1'b1, "R10 idle line high", int'(txd), 1);

      // vector table: R1 R2 R3 R4
      for (int v = 0; v < 8; v++) begin
         {d, cfg_len_sel, cfg_par_en, cfg_par_odd, cfg_stop_long, cfg_fifo_mode} = VEC[v];
         n = 5 + int'(cfg_len_sel);
         p = int'(cfg_par_en);
         sl = int'(cfg_stop_long);
         repeat (2) @(negedge clk);
         fork
            wr(d);
            recv(n, p, bits, i);
         join
         exp_d = '0;
         for (int j = 0; j < n; j++) exp_d[j] = d[j];
         exp_p = (^exp_d) ^ cfg_par_odd;
         check(bits[0] === 1'b0, "R2 start bit low", int'(bits[0]), 0);
         check(decode(bits, n) === exp_d, "R1 data bits", int'(decode(bits, n)), int'(exp_d));
         if (p == 1)
            check(bits[n + 1] === exp_p, "R3 parity bit", int'(bits[n + 1]), int'(exp_p));
         check(bits[n + 1 + p] === 1'b1, "R4 stop level", int'(bits[n + 1 + p]), 1);
         wait_idle(i);
         t = frame_ticks(n, p, sl);
         check(i == t, "R4 frame length in ticks", i, t);
      end

      // R9 break forcing
      cfg_break = 1'b1;
      repeat (2) @(negedge clk);
      check(txd === 1'b0, "R9 break forces low", int'(txd), 0);
      cfg_break = 1'b0;
      @(negedge clk);
      check(txd === 1'b1, "R9 line released", int'(txd), 1);

      // R6 character mode: one slot, third write dropped
      cfg_len_sel = 2'd3; cfg_par_en = 1'b0; cfg_stop_long = 1'b0; cfg_fifo_mode = 1'b0;
      repeat (2) @(negedge clk);
      fork
         begin
            wr(8'h11); wr(8'h22);
            check(buf_empty === 1'b0, "R6 holding slot occupied", int'(buf_empty), 0);
            wr(8'h33);
         end
         begin
            recv(8, 0, bits, i);
            check(decode(bits, 8) === 8'h11, "R6 first char", int'(decode(bits, 8)), 'h11);
            recv(8, 0, bits, i);
            check(decode(bits, 8) === 8'h22, "R6 second char", int'(decode(bits, 8)), 'h22);
            wait_idle(i);
            check(i == 160, "R6 third write dropped", i, 160);
         end
      join

      // R7 FIFO mode: 16 queued plus one in flight, 18th dropped
      cfg_fifo_mode = 1'b1;
      repeat (2) @(negedge clk);
      fork
         begin
            for (int k = 0; k < 18; k++) wr(8'(k * 7 + 3));
         end
         begin
            for (int k = 0; k < 17; k++) begin
               recv(8, 0, bits, i);
               check(decode(bits, 8) === 8'(k * 7 + 3), "R7 FIFO order",
                     int'(decode(bits, 8)), k * 7 + 3);
            end
            wait_idle(i);
            check(i == 160, "R7 write to full FIFO dropped", i, 160);
         end
      join

      // R8 mode switch flushes the buffer, current frame completes
      fork
         begin
            wr(8'h5A); wr(8'h66); wr(8'h77);
            repeat (20) @(negedge clk);
            check(buf_empty === 1'b0, "R8 buffer filled before switch", int'(buf_empty), 0);
            cfg_fifo_mode = 1'b0;
            repeat (2) @(negedge clk);
            check(buf_empty === 1'b1, "R8 buffer flushed", int'(buf_empty), 1);
         end
         begin
            recv(8, 0, bits, i);
            check(decode(bits, 8) === 8'h5A, "R8 frame in flight completes",
                  int'(decode(bits, 8)), 'h5A);
            wait_idle(i);
            check(i == 160, "R8 no frame after flush", i, 160);
         end
      join

      // R5 no ticks: frame stalls in start bit
      tick_mode = 0;
      repeat (2) @(negedge clk);
      wr(8'hC3);
      repeat (40) @(negedge clk);
      check(txd === 1'b0, "R5 start bit held without ticks", int'(txd), 0);
      check(tx_idle === 1'b0, "R5 not idle while stalled", int'(tx_idle), 0);
      tick_mode = 1;
      i = 0;
      wait_idle(i);
      repeat (2) @(negedge clk);

      // R5 pacing with a tick every third cycle
      tick_mode = 3;
      repeat (4) @(negedge clk);
      fork
         wr(8'h96);
         begin
            do @(negedge clk); while (txd !== 1'b0);
            i = 0;
            wait_idle(i);
         end
      join
      check(i >= 3 * 160 - 2 && i <= 3 * 160, "R5 duration scales with tick rate", i, 480);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule